// File: doc/BRIEF.md
# Aligned DMA Read Request Splitter

This block turns one host-memory read job into a stream of burst read requests for a service DMA channel that moves data from host memory into on-chip SRAM. Software writes the host source address, the SRAM destination address and the byte count through a small register port. It then writes the control word with the start bit set. From that point the block issues read requests, each carrying a host address, an SRAM address and a length. It also counts completions, which arrive in the order the requests were issued.

Each request length depends on the selected burst size, on the alignment of the current host address and on the bytes still to be read. The number of reads in flight is capped by a programmable credit limit. Once every byte has been requested and every request has completed, the start bit clears itself. If the interrupt enable is set, a one-cycle done pulse is raised.

The control word layout is as follows:
- Bits [3:0] hold the raw outstanding-request cap.
- Bits [9:8] select the burst size.
- Bit 10 enables split mode.
- Bit 24 enables the done interrupt.
- Bit 31 is the start/busy bit.

Registers are selected by `cfg_sel`: 0 control, 1 host address, 2 SRAM address, 3 byte count.

Top module: `rd_burst_splitter`

## Requirements
- R1: After reset every register reads zero, `busy`, `req_valid` and `irq_done` are low.
- R2: While idle, a write stores `cfg_wdata` in the register chosen by `cfg_sel`, and `cfg_rdata` returns it zero-extended to its implemented width (host address 32 bits, SRAM address 16 bits, byte count 16 bits, control 32 bits).
- R3: While a job is running, writes to any register are ignored: every readback stays as it was, including the control word.
- R4: Writing the control word with bit 31 set while idle starts a job. `busy` (and control bit 31) is high from the next cycle on, and falls one cycle after the final completion has been accepted, with nothing outstanding at that point.
- R5: Control bits [9:8] pick the burst size: 0 selects 64 bytes, 1 selects 128 bytes, and 2 or 3 select 256 bytes. Outside the case in R6, no request crosses an address boundary of the chosen size.
- R6: With control bit 10 set and a 128-byte size, a request whose host address is not 128-byte aligned ends at or before the next 64-byte boundary.
- R7: Each request carries the smaller of the boundary room and the remaining byte count. The count may be any value, including one that is not a multiple of 4. The lengths sum to the count. A count of zero issues no request and still completes.
- R8: Each request's host address and SRAM address are the previous request's addresses plus its length, starting from the programmed values.
- R9: Control bits [3:0] set the maximum number of outstanding requests. A value of 0 acts as 1, and values above 12 act as 12. `req_valid` is high exactly when bytes remain and fewer than that many requests are outstanding.
- R10: Each `cpl_valid` cycle retires one outstanding request. A completion with nothing outstanding is ignored.
- R11: When control bit 24 is set, `irq_done` pulses for exactly the one cycle in which `busy` first reads low after a job. When bit 24 is clear, `irq_done` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select for write and readback |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Readback of the selected register |
| busy | output | 1 | Job in progress |
| irq_done | output | 1 | One-cycle done interrupt |
| req_valid | output | 1 | Read request offered |
| req_ready | input | 1 | Read request accepted |
| req_host_addr | output | 32 | Host byte address of the request |
| req_sram_addr | output | 16 | SRAM byte address of the request |
| req_len | output | 9 | Request length in bytes (1 to 256) |
| cpl_valid | input | 1 | One in-order read completion |

## Verification
Several properties are checked on every cycle:
- the in-flight count never exceeds the clamped cap;
- no offered request crosses its size boundary or, in split mode, a 64-byte boundary from an unaligned address;
- a request length is nonzero and never exceeds the remaining count;
- addresses step by exactly the accepted length;
- `busy` only falls with nothing left or outstanding;
- the interrupt only fires on that falling edge.

Other behaviours can only be shown by the bench's scenarios:
- that the request sequence matches an independently computed split over a sweep of sizes, offsets, counts and caps;
- that `req_valid` is asserted whenever credit exists and not only withheld when it does not;
- that register writes during a job leave the readback unchanged;
- that a completion while idle does not corrupt the credit count.

// File: rtl/rbs_pkg.sv
package rbs_pkg;

  localparam int REG_W     = 32;
  localparam int LEN_W     = 9;
  localparam int CAP_W     = 4;
  localparam int CAP_LIMIT = 12;

  localparam int CTL_START = 31;
  localparam int CTL_IRQ   = 24;
  localparam int CTL_SPLIT = 10;
  localparam int CTL_SZ_LO = 8;
  localparam int CTL_CAP_LO = 0;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_HOST  = 2'd1,
    SEL_SRAM  = 2'd2,
    SEL_COUNT = 2'd3
  } reg_sel_e;

  // Burst size in bytes for a size code.
  function automatic logic [LEN_W-1:0] size_bytes(input logic [1:0] code);
    logic [LEN_W-1:0] s;
    case (code)
      2'd0:    s = 9'd64;
      2'd1:    s = 9'd128;
      default: s = 9'd256;
    endcase
    return s;
  endfunction

  // Bytes from the low address bits up to the next allowed boundary.
  function automatic logic [LEN_W-1:0] chunk_room(input logic [7:0] lo,
                                                  input logic [1:0] code,
                                                  input logic split);
    logic [LEN_W-1:0] sz;
    logic [LEN_W-1:0] off;
    logic [LEN_W-1:0] room;
    sz = size_bytes(code);
    if (split && code == 2'd1 && lo[6:0] != 7'd0) begin
      room = 9'd64 - {3'b000, lo[5:0]};
    end else begin
      off  = {1'b0, lo} & (sz - 9'd1);
      room = sz - off;
    end
    return room;
  endfunction

  // Effective outstanding-request limit.
  function automatic logic [CAP_W-1:0] eff_cap(input logic [CAP_W-1:0] raw);
    logic [CAP_W-1:0] c;
    if (raw == '0)
      c = CAP_W'(1);
    else if (raw > CAP_W'(CAP_LIMIT))
      c = CAP_W'(CAP_LIMIT);
    else
      c = raw;
    return c;
  endfunction

endpackage

// File: rtl/rbs_cfg_regs.sv
module rbs_cfg_regs
  import rbs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SRAM_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              job_done,
  output logic [REG_W-1:0]  cfg_rdata,
  output logic [REG_W-1:0]  ctrl_q,
  output logic [ADDR_W-1:0] host_q,
  output logic [SRAM_W-1:0] sram_q,
  output logic [CNT_W-1:0]  count_q,
  output logic              start_fire
);

  reg_sel_e sel;
  logic     idle;

  assign sel        = reg_sel_e'(cfg_sel);
  assign idle       = !ctrl_q[CTL_START];
  assign start_fire = cfg_we && idle && (sel == SEL_CTRL) && cfg_wdata[CTL_START];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      host_q  <= '0;
      sram_q  <= '0;
      count_q <= '0;
    end else begin
      if (job_done)
        ctrl_q[CTL_START] <= 1'b0;
      if (cfg_we && idle) begin
        case (sel)
          SEL_CTRL:  ctrl_q  <= cfg_wdata;
          SEL_HOST:  host_q  <= cfg_wdata[ADDR_W-1:0];
          SEL_SRAM:  sram_q  <= cfg_wdata[SRAM_W-1:0];
          SEL_COUNT: count_q <= cfg_wdata[CNT_W-1:0];
          default:   ;
        endcase
      end
    end
  end

  always_comb begin
    case (sel)
      SEL_CTRL:  cfg_rdata = ctrl_q;
      SEL_HOST:  cfg_rdata = REG_W'(host_q);
      SEL_SRAM:  cfg_rdata = REG_W'(sram_q);
      SEL_COUNT: cfg_rdata = REG_W'(count_q);
      default:   cfg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/rbs_chunker.sv
module rbs_chunker
  import rbs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SRAM_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] host_base,
  input  logic [SRAM_W-1:0] sram_base,
  input  logic [CNT_W-1:0]  count,
  input  logic [1:0]        size_code,
  input  logic              split_on,
  input  logic              advance,
  output logic [ADDR_W-1:0] cur_host,
  output logic [SRAM_W-1:0] cur_sram,
  output logic [CNT_W-1:0]  rem_bytes,
  output logic [LEN_W-1:0]  cur_len
);

  logic [LEN_W-1:0] room;

  assign room = chunk_room(cur_host[7:0], size_code, split_on);

  always_comb begin
    if (rem_bytes < CNT_W'(room))
      cur_len = rem_bytes[LEN_W-1:0];
    else
      cur_len = room;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_host  <= '0;
      cur_sram  <= '0;
      rem_bytes <= '0;
    end else if (load) begin
      cur_host  <= host_base;
      cur_sram  <= sram_base;
      rem_bytes <= count;
    end else if (advance) begin
      cur_host  <= cur_host + ADDR_W'(cur_len);
      cur_sram  <= cur_sram + SRAM_W'(cur_len);
      rem_bytes <= rem_bytes - CNT_W'(cur_len);
    end
  end

endmodule

// File: rtl/rbs_credit.sv
module rbs_credit
  import rbs_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             retire,
  input  logic [CAP_W-1:0] cap,
  output logic [CAP_W-1:0] outstanding,
  output logic             has_credit
);

  logic retire_ok;

  assign retire_ok  = retire && (outstanding != '0);
  assign has_credit = outstanding < cap;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outstanding <= '0;
    end else begin
      case ({issue, retire_ok})
        2'b10:   outstanding <= outstanding + CAP_W'(1);
        2'b01:   outstanding <= outstanding - CAP_W'(1);
        default: outstanding <= outstanding;
      endcase
    end
  end

endmodule

// File: rtl/rd_burst_splitter.sv
module rd_burst_splitter
  import rbs_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SRAM_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  output logic              busy,
  output logic              irq_done,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_host_addr,
  output logic [SRAM_W-1:0] req_sram_addr,
  output logic [8:0]        req_len,
  input  logic              cpl_valid
);

  logic [REG_W-1:0]  ctrl_q;
  logic [ADDR_W-1:0] host_q;
  logic [SRAM_W-1:0] sram_q;
  logic [CNT_W-1:0]  count_q;
  logic              start_fire;
  logic              job_done;
  logic              issue_fire;
  logic [CNT_W-1:0]  rem_bytes;
  logic [CAP_W-1:0]  outstanding;
  logic [CAP_W-1:0]  cap_eff;
  logic              has_credit;
  logic [1:0]        size_code;
  logic              split_on;
  logic              irq_en;
  logic              bytes_left;

  assign size_code  = ctrl_q[CTL_SZ_LO +: 2];
  assign split_on   = ctrl_q[CTL_SPLIT];
  assign irq_en     = ctrl_q[CTL_IRQ];
  assign cap_eff    = eff_cap(ctrl_q[CTL_CAP_LO +: CAP_W]);
  assign busy       = ctrl_q[CTL_START];
  assign bytes_left = rem_bytes != '0;
  assign req_valid  = busy && bytes_left && has_credit;
  assign issue_fire = req_valid && req_ready;
  assign job_done   = busy && !bytes_left && (outstanding == '0);

  rbs_cfg_regs #(.ADDR_W(ADDR_W), .SRAM_W(SRAM_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_we     (cfg_we),
    .cfg_sel    (cfg_sel),
    .cfg_wdata  (cfg_wdata),
    .job_done   (job_done),
    .cfg_rdata  (cfg_rdata),
    .ctrl_q     (ctrl_q),
    .host_q     (host_q),
    .sram_q     (sram_q),
    .count_q    (count_q),
    .start_fire (start_fire)
  );

  rbs_chunker #(.ADDR_W(ADDR_W), .SRAM_W(SRAM_W), .CNT_W(CNT_W)) u_chunk (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (start_fire),
    .host_base (host_q),
    .sram_base (sram_q),
    .count     (count_q),
    .size_code (size_code),
    .split_on  (split_on),
    .advance   (issue_fire),
    .cur_host  (req_host_addr),
    .cur_sram  (req_sram_addr),
    .rem_bytes (rem_bytes),
    .cur_len   (req_len)
  );

  rbs_credit u_credit (
    .clk         (clk),
    .rst_n       (rst_n),
    .issue       (issue_fire),
    .retire      (cpl_valid),
    .cap         (cap_eff),
    .outstanding (outstanding),
    .has_credit  (has_credit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)
      irq_done <= 1'b0;
    else
      irq_done <= job_done && irq_en;
  end

endmodule

// File: rtl/rd_burst_splitter_chk.sv
module rd_burst_splitter_chk #(
  parameter int ADDR_W = 32,
  parameter int SRAM_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              irq_done,
  input logic              irq_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_host_addr,
  input logic [SRAM_W-1:0] req_sram_addr,
  input logic [8:0]        req_len,
  input logic [CNT_W-1:0]  rem_bytes,
  input logic [3:0]        outstanding,
  input logic [3:0]        cap_eff,
  input logic [1:0]        size_code,
  input logic              split_on
);

  logic [9:0] sz_w;
  logic       split_case;
  logic       fire;

  assign sz_w       = (size_code == 2'd0) ? 10'd64 : (size_code == 2'd1) ? 10'd128 : 10'd256;
  assign split_case = split_on && (size_code == 2'd1) && (req_host_addr[6:0] != 7'd0);
  assign fire       = req_valid && req_ready;

  AST_CAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    outstanding <= cap_eff); // R9

  AST_SIZE_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !split_case) |->
      ((({2'b00, req_host_addr[7:0]} & (sz_w - 10'd1)) + {1'b0, req_len}) <= sz_w)); // R5

  AST_SPLIT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && split_case) |-> (({4'd0, req_host_addr[5:0]} + {1'b0, req_len}) <= 10'd64)); // R6

  AST_LEN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != 9'd0) && (CNT_W'(req_len) <= rem_bytes)); // R7

  AST_SRAM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (CNT_W'(req_len) != rem_bytes)) |=>
      (req_sram_addr == $past(req_sram_addr) + SRAM_W'($past(req_len)))); // R8

  AST_HOST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && (CNT_W'(req_len) != rem_bytes)) |=>
      (req_host_addr == $past(req_host_addr) + ADDR_W'($past(req_len)))); // R8

  AST_DONE_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (outstanding == 4'd0) && (rem_bytes == '0)); // R4

  AST_IRQ_ONLY_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    irq_done |-> (!busy && $past(busy) && irq_en)); // R11

endmodule

bind rd_burst_splitter rd_burst_splitter_chk #(
  .ADDR_W(ADDR_W), .SRAM_W(SRAM_W), .CNT_W(CNT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .busy          (busy),
  .irq_done      (irq_done),
  .irq_en        (irq_en),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .req_host_addr (req_host_addr),
  .req_sram_addr (req_sram_addr),
  .req_len       (req_len),
  .rem_bytes     (rem_bytes),
  .outstanding   (outstanding),
  .cap_eff       (cap_eff),
  .size_code     (size_code),
  .split_on      (split_on)
);

// File: tb/rd_burst_splitter_test.sv
module rd_burst_splitter_test;

  localparam logic [1:0] S_CTRL = 2'd0, S_HOST = 2'd1, S_SRAM = 2'd2, S_CNT = 2'd3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        busy, irq_done, req_valid;
  logic        req_ready = 1'b0;
  logic [31:0] req_host_addr;
  logic [15:0] req_sram_addr;
  logic [8:0]  req_len;
  logic        cpl_valid = 1'b0;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #4 clk = ~clk;

  rd_burst_splitter uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .busy(busy),
    .irq_done(irq_done), .req_valid(req_valid), .req_ready(req_ready),
    .req_host_addr(req_host_addr), .req_sram_addr(req_sram_addr),
    .req_len(req_len), .cpl_valid(cpl_valid)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    cfg_sel = sel;
    #1;
    d = cfg_rdata;
  endtask

  function automatic int exp_len(input logic [31:0] a, input int rem, input int size, input int split);
    int sz, lim;
    sz = (size == 0) ? 64 : (size == 1) ? 128 : 256;
    if (split != 0 && size == 1 && (a % 128) != 0)
      lim = 64 - int'(a % 64);
    else
      lim = sz - int'(a % sz);
    return (rem < lim) ? rem : lim;
  endfunction

  task automatic run_job(input logic [31:0] host, input logic [15:0] sram, input int count,
                         input int size, input int split, input int cap_raw, input bit irq);
    int m_rem, m_out, capx, elen;
    logic [31:0] m_host, d;
    logic [15:0] m_sram;
    bit rdy, cpl, fire;
    wr(S_HOST, host);
    wr(S_SRAM, {16'h0, sram});
    wr(S_CNT, count);
    wr(S_CTRL, (32'h1 << 31) | (32'(irq) << 24) | (32'(split) << 10) | (32'(size) << 8) | 32'(cap_raw));
    chk("R4 busy after start", {31'b0, busy}, 32'd1);
    m_host = host; m_sram = sram; m_rem = count; m_out = 0;
    capx = (cap_raw == 0) ? 1 : (cap_raw > 12) ? 12 : cap_raw;
    for (int cyc = 0; cyc < 4000; cyc++) begin
      if (m_rem == 0 && m_out == 0) break;
      chk("R9 R10 req_valid vs credit", {31'b0, req_valid}, {31'b0, (m_rem > 0 && m_out < capx)});
      elen = 0;
      if (m_rem > 0) elen = exp_len(m_host, m_rem, size, split);
      if (req_valid && m_rem > 0 && m_out < capx) begin
        chk("R5 R6 R7 req_len", {23'b0, req_len}, elen);
        chk("R8 host address", req_host_addr, m_host);
        chk("R8 sram address", {16'b0, req_sram_addr}, {16'b0, m_sram});
      end
      rdy = lfsr[0] | lfsr[3];
      cpl = (m_out > 0) && (lfsr[5] | lfsr[7]);
      req_ready = rdy;
      cpl_valid = cpl;
      fire = req_valid && rdy && m_rem > 0;
      if (fire) begin
        m_host = m_host + 32'(elen);
        m_sram = m_sram + 16'(elen);
        m_rem  = m_rem - elen;
        m_out++;
      end
      if (cpl) m_out--;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      @(negedge clk);
    end
    req_ready = 1'b0;
    cpl_valid = 1'b0;
    chk("R4 busy until last retire seen", {31'b0, busy}, 32'd1);
    @(negedge clk);
    chk("R4 busy falls", {31'b0, busy}, 32'd0);
    chk("R11 irq pulse", {31'b0, irq_done}, {31'b0, irq});
    rd(S_CTRL, d);
    chk("R4 start bit self-clears", {31'b0, d[31]}, 32'd0);
    @(negedge clk);
    chk("R11 irq one cycle", {31'b0, irq_done}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int offs[7];
    int cnts[5];
    int caps[5];
    int job;
    offs = '{0, 4, 60, 64, 100, 127, 192};
    cnts = '{0, 1, 3, 130, 517};
    caps = '{0, 1, 3, 12, 15};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      rd(2'(s), d);
      chk("R1 reset readback", d, 32'd0);
    end
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 req_valid", {31'b0, req_valid}, 32'd0);
    chk("R1 irq", {31'b0, irq_done}, 32'd0);

    // R2 readback while idle
    wr(S_HOST, 32'hDEAD_BEEF);
    wr(S_SRAM, 32'h1234_5678);
    wr(S_CNT,  32'h1234_ABCD);
    wr(S_CTRL, 32'h0100_0503);
    rd(S_HOST, d); chk("R2 host readback", d, 32'hDEAD_BEEF);
    rd(S_SRAM, d); chk("R2 sram readback", d, 32'h0000_5678);
    rd(S_CNT, d);  chk("R2 count readback", d, 32'h0000_ABCD);
    rd(S_CTRL, d); chk("R2 ctrl readback", d, 32'h0100_0503);
    chk("R2 no start without bit 31", {31'b0, busy}, 32'd0);

    // R3 writes ignored while busy
    wr(S_HOST, 32'h0000_1000);
    wr(S_SRAM, 32'h0000_0040);
    wr(S_CNT, 32'd8);
    wr(S_CTRL, 32'h8000_0001);
    chk("R3 started", {31'b0, busy}, 32'd1);
    wr(S_HOST, 32'h5555_5555);
    wr(S_SRAM, 32'h0000_7777);
    wr(S_CNT, 32'd999);
    wr(S_CTRL, 32'h8100_020C);
    rd(S_HOST, d); chk("R3 host unchanged", d, 32'h0000_1000);
    rd(S_SRAM, d); chk("R3 sram unchanged", d, 32'h0000_0040);
    rd(S_CNT, d);  chk("R3 count unchanged", d, 32'd8);
    rd(S_CTRL, d); chk("R3 ctrl unchanged", d, 32'h8000_0001);
    chk("R7 short job length", {23'b0, req_len}, 32'd8);
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    chk("R9 cap 1 blocks second", {31'b0, req_valid}, 32'd0);
    cpl_valid = 1'b1;
    @(negedge clk);
    cpl_valid = 1'b0;
    @(negedge clk);
    chk("R4 R3 job ends", {31'b0, busy}, 32'd0);
    chk("R11 irq disabled", {31'b0, irq_done}, 32'd0);

    // R10 stray completion while idle must not disturb credit
    cpl_valid = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cpl_valid = 1'b0;
    run_job(32'h0002_0000, 16'h0200, 200, 0, 0, 1, 1'b1);

    // Sweep of size, split, offset, count and cap
    job = 0;
    for (int sz = 0; sz < 4; sz++)
      for (int sp = 0; sp < 2; sp++)
        for (int oi = 0; oi < 7; oi++)
          for (int ci = 0; ci < 5; ci++)
            for (int ki = 0; ki < 5; ki++) begin
              run_job(32'h0001_0000 + 32'(job * 512) + 32'(offs[oi]),
                      16'h0100 + 16'(offs[oi] * 3), cnts[ci], sz, sp, caps[ki], job[0]);
              job++;
            end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule